// File: doc/BRIEF.md
# Infrared Remote Carrier Generator

This block makes the modulation carrier for an infrared remote-control transmitter. A free-running prescaler divides the clock by a power of two. A 4-bit select code picks the ratio, and the chosen ratio produces a one-cycle counting tick. A phase state machine counts those ticks: it holds the carrier high for one programmed length, then low for a second programmed length, and repeats. Because the two lengths are separate, the carrier can have any duty cycle, symmetric or not.

The machine has three states. `PH_IDLE` drives the carrier low and keeps the counter at zero. `PH_HIGH` drives the carrier high. `PH_LOW` drives it low. The transitions are:

- IDLE to HIGH, taken when the enable is seen.
- HIGH to LOW, taken on the tick where the count equals the latched high length.
- LOW to HIGH, taken on the tick where the count equals the latched low length.
- Any state to IDLE, taken whenever the enable is low.

The select code and both lengths are latched each time a phase starts. Code 0xF is reserved, and the block reads it as a tick that never comes.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, `carrier_out` is 0.
- R2: A rising `enable` makes `carrier_out` 1 from the next clock edge. The high phase starts at count 0. With select 0, that first high phase lasts exactly `high_len`+1 cycles.
- R3: Once running, every high phase lasts (`high_len`+1) × 2^`div_sel` clock cycles.
- R4: Once running, every low phase lasts (`low_len`+1) × 2^`div_sel` clock cycles.
- R5: Select codes 0x0 through 0xE divide the clock by 2^code. Code 0 gives a tick on every clock.
- R6: Select code 0xF produces no tick. Once latched, `carrier_out` holds its present level, high or low, until enable drops.
- R7: When `enable` is 0 at a clock edge, `carrier_out` is 0 after that edge and the phase count is cleared. A later enable therefore starts a full high phase.
- R8: `div_sel`, `high_len` and `low_len` are sampled only when a phase begins. A change made partway through a phase does not shorten or lengthen that phase. It applies from the following phase onward.
- R9: Phases alternate high then low. While enable stays high, the carrier changes level only on a prescaler tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the carrier when 1; forces idle when 0 |
| div_sel | input | 4 | Prescaler ratio code, divisor 2^code; 0xF reserved |
| high_len | input | 6 | High phase length minus one, in ticks |
| low_len | input | 6 | Low phase length minus one, in ticks |
| carrier_out | output | 1 | Carrier bit |

## Verification
A corrupted phase count or latched length appears at `carrier_out` as a phase of the wrong duration. The error shows by the end of the phase in which it happens, which is at most 64 × 2^code cycles later. A prescaler mask error stretches or shrinks every phase by a power-of-two factor, so one full low or high run measured in cycles exposes it. A wrong state transition shows as a missing level change, or a change that comes one cycle early or late after enable.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
    localparam int SEL_W_DEF = 4;
    localparam int LEN_W_DEF = 6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/ircg_prescaler.sv
module ircg_prescaler #(
    parameter int SEL_W = ircg_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int RSVD  = (1 << SEL_W) - 1;
    localparam int CNT_W = RSVD - 1;

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    // bit g takes part in the compare when the code selects more than g bits
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask[g] = (sel > SEL_W'(g));
    end

    always_comb begin
        if (sel == SEL_W'(RSVD)) tick = 1'b0;
        else                     tick = &(div_cnt | ~mask);
    end
endmodule

// File: rtl/ircg_phase_fsm.sv
module ircg_phase_fsm #(
    parameter int SEL_W = ircg_pkg::SEL_W_DEF,
    parameter int LEN_W = ircg_pkg::LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [LEN_W-1:0] high_in,
    input  logic [LEN_W-1:0] low_in,
    output logic [SEL_W-1:0] sel_q,
    output logic [LEN_W-1:0] phase_cnt,
    output logic [LEN_W-1:0] cur_len,
    output logic             carrier
);
    import ircg_pkg::*;

    phase_e           state_q, state_d;
    logic [LEN_W-1:0] cnt_d;
    logic [LEN_W-1:0] high_q, low_q;
    logic             load;
    logic             at_end;

    assign cur_len = (state_q == PH_LOW) ? low_q : high_q;
    assign at_end  = tick && (phase_cnt == cur_len);

    always_comb begin
        state_d = state_q;
        cnt_d   = phase_cnt;
        load    = 1'b0;
        if (!enable) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d = PH_HIGH;
                    cnt_d   = '0;
                    load    = 1'b1;
                end
                PH_HIGH: begin
                    if (at_end) begin
                        state_d = PH_LOW;
                        cnt_d   = '0;
                        load    = 1'b1;
                    end else if (tick) begin
                        cnt_d = phase_cnt + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (at_end) begin
                        state_d = PH_HIGH;
                        cnt_d   = '0;
                        load    = 1'b1;
                    end else if (tick) begin
                        cnt_d = phase_cnt + 1'b1;
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PH_IDLE;
            phase_cnt <= '0;
            high_q    <= '0;
            low_q     <= '0;
            sel_q     <= '0;
        end else begin
            state_q   <= state_d;
            phase_cnt <= cnt_d;
            if (load) begin
                high_q <= high_in;
                low_q  <= low_in;
                sel_q  <= sel_in;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            PH_HIGH: carrier = 1'b1;
            PH_LOW:  carrier = 1'b0;
            default: carrier = 1'b0;
        endcase
    end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
    parameter int SEL_W = ircg_pkg::SEL_W_DEF,
    parameter int LEN_W = ircg_pkg::LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [LEN_W-1:0] high_len,
    input  logic [LEN_W-1:0] low_len,
    output logic             carrier_out
);
    logic             tick;
    logic [SEL_W-1:0] sel_q;
    logic [LEN_W-1:0] phase_cnt;
    logic [LEN_W-1:0] cur_len;

    ircg_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (sel_q),
        .tick (tick)
    );

    ircg_phase_fsm #(.SEL_W(SEL_W), .LEN_W(LEN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick     (tick),
        .sel_in   (div_sel),
        .high_in  (high_len),
        .low_in   (low_len),
        .sel_q    (sel_q),
        .phase_cnt(phase_cnt),
        .cur_len  (cur_len),
        .carrier  (carrier_out)
    );
endmodule

// File: rtl/ircg_chk.sv
module ircg_chk #(
    parameter int SEL_W = ircg_pkg::SEL_W_DEF,
    parameter int LEN_W = ircg_pkg::LEN_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             carrier_out,
    input logic             tick,
    input logic [SEL_W-1:0] sel_q,
    input logic [LEN_W-1:0] phase_cnt,
    input logic [LEN_W-1:0] cur_len
);
    logic en_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= enable;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) !rst_n |-> !carrier_out);

    // R2
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> carrier_out);

    // R7
    disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!carrier_out && phase_cnt == '0));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_cnt <= cur_len);

    // R5
    div1_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |-> tick);

    // R6
    rsvd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == {SEL_W{1'b1}}) |-> !tick);

    // R9
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && en_d && !tick) |=> $stable(carrier_out));

    // R9
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(carrier_out) && $past(enable)) |-> $past(tick));
endmodule

bind ir_carrier_gen ircg_chk #(.SEL_W(SEL_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .carrier_out(carrier_out),
    .tick       (tick),
    .sel_q      (sel_q),
    .phase_cnt  (phase_cnt),
    .cur_len    (cur_len)
);

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] div_sel = 4'd0;
    logic [5:0] high_len = 6'd0;
    logic [5:0] low_len = 6'd0;
    logic       carrier_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ir_carrier_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .high_len(high_len), .low_len(low_len), .carrier_out(carrier_out)
    );

    // {sel, high, low}
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0,  6'd0,  6'd0},
        {4'd0,  6'd63, 6'd63},
        {4'd1,  6'd2,  6'd1},
        {4'd2,  6'd2,  6'd1},
        {4'd3,  6'd5,  6'd10},
        {4'd4,  6'd0,  6'd7},
        {4'd5,  6'd3,  6'd3},
        {4'd14, 6'd0,  6'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl);
        int k = 0;
        while (carrier_out !== lvl && k < 70000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (carrier_out === lvl && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input logic [3:0] s, input logic [5:0] h, input logic [5:0] l);
        @(negedge clk);
        enable = 1'b0;
        div_sel = s; high_len = h; low_len = l;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nh, nl;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", int'(carrier_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after reset, enable low", int'(carrier_out), 0);

        // R3 R4 R5: table of steady-state phase lengths
        for (int i = 0; i < NV; i++) begin
            logic [3:0] s;
            logic [5:0] h, l;
            s = VEC[i][15:12]; h = VEC[i][11:6]; l = VEC[i][5:0];
            restart(s, h, l);
            wait_level(1'b0);
            run_len(1'b0, nl);
            run_len(1'b1, nh);
            check("R4 low phase length", nl, (int'(l) + 1) << s);
            check("R3 high phase length", nh, (int'(h) + 1) << s);
        end

        // R2: first high phase exact with divide by 1
        restart(4'd0, 6'd4, 6'd2);
        check("R2 high right after enable", int'(carrier_out), 1);
        run_len(1'b1, nh);
        check("R2 first high length", nh, 5);

        // R7: disable mid-phase clears count
        restart(4'd0, 6'd5, 6'd3);
        @(negedge clk); @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R7 low after disable", int'(carrier_out), 0);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, nh);
        check("R7 full high after re-enable", nh, 6);

        // R8: mid-phase length change applies to the next phase only
        restart(4'd0, 6'd9, 6'd9);
        high_len = 6'd1;
        run_len(1'b1, nh);
        check("R8 current high not cut", nh, 10);
        run_len(1'b0, nl);
        check("R8 low unchanged", nl, 10);
        run_len(1'b1, nh);
        check("R8 next high uses new length", nh, 2);

        // R6: reserved code stalls with carrier high
        restart(4'd15, 6'd0, 6'd0);
        repeat (300) @(negedge clk);
        check("R6 hold high on reserved code", int'(carrier_out), 1);

        // R6 R8: reserved code latched at boundary stalls low
        restart(4'd0, 6'd2, 6'd2);
        div_sel = 4'd15;
        run_len(1'b1, nh);
        check("R8 high finishes before new code", nh, 3);
        repeat (300) @(negedge clk);
        check("R6 hold low on reserved code", int'(carrier_out), 0);

        // R1: reset while running
        restart(4'd0, 6'd3, 6'd3);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset while running", int'(carrier_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_len(1'b1, nh);
        check("R2 high after reset release", nh, 4);

        finish_run();
    end
endmodule